// File: doc/BRIEF.md
# Fault Suspicion Ranking Engine

This block turns per-channel anomaly flags from a comparator stage into a short ranked list of the DC bus segments most likely to carry a ground fault. A rising edge on the global insulation alarm opens a scan window. During the window, each sample beat on the input stream adds to a per-segment suspicion score. The score grows with the order in which channels first go abnormal, with how long they stay abnormal, and with how often a configured far-end channel exceeds a near-end reference by a ratio.

When the window has taken its configured number of beats, the engine selects the three best segments one candidate per clock. It then presents their identifiers and scores, together with the timestamps at which the window opened and closed, and raises a one-cycle done pulse. A fixed parameter maps each channel to a segment, so several channels, such as a current and a voltage channel, can credit the same rack.

The sample input is a valid/ready stream. The engine holds ready high while idle or scanning. Beats that arrive while idle are consumed and discarded. Ready is low for the whole sort phase, and the upstream must hold its beat until ready returns. Control and result pins are plain signals.

Top module: `fsr_rank_engine`

## Requirements
- R1: After reset all rank outputs, both window timestamps and done are 0, ready is 1 and scan_active is 0; the alarm must fall and rise again after reset before a window opens.
- R2: A rising alarm edge while idle sets scan_active on the next cycle and stores time_i of that edge in win_start_o, which then holds until the next window opens.
- R3: The window closes on the accepted beat that brings the beat count to cfg_win_len (a value of 0 acts as 1); win_end_o takes time_i of that beat.
- R4: Points for the first abnormal beat of a channel, counted per beat that contains any new crossing: 4 in the first such beat, 2 in the second, 1 in the third, 0 afterwards. Channels that first cross in the same beat all receive the same points.
- R5: Every beat inside the window adds 1 per abnormal channel to that channel's segment, using the map field CH_SEG_MAP[4c+3:4c]. The default map puts channels 2k and 2k+1 on segment k.
- R6: Every beat inside the window where far_mag*cfg_ratio_den > near_mag*cfg_ratio_num adds 1 to the segment of channel cfg_far_ch. Far and near magnitudes are the 12-bit fields of s_mag_i at the configured channel indices.
- R7: Scores saturate at 255.
- R8: The ranked order puts the higher score first. Equal scores put first the segment whose first crossing has the earlier timestamp, where a segment that never crossed ranks after one that did. After that, the lower segment index goes first. The result is three distinct segments: rank k occupies rank_seg_o[4k+3:4k] and rank_score_o[8k+7:8k].
- R9: done_o is a one-cycle pulse that comes exactly 3*NUM_SEG cycles after the closing beat. Rank outputs change only in the done cycle.
- R10: s_ready_o is low from the cycle after the closing beat until done. Beats accepted while idle change no score.
- R11: Alarm edges while a window is open or sorting is in progress are ignored. They neither restart nor extend the window, and they open no new window after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_i | input | 1 | Global insulation alarm; rising edge opens a window |
| time_i | input | TS_W | Common time base value |
| cfg_win_len | input | WIN_W | Window length in accepted beats |
| cfg_far_ch | input | CH_W | Far-end channel for the ratio test |
| cfg_near_ch | input | CH_W | Near-end reference channel |
| cfg_ratio_num | input | RATIO_W | Ratio numerator (multiplies near) |
| cfg_ratio_den | input | RATIO_W | Ratio denominator (multiplies far) |
| s_valid_i | input | 1 | Sample beat valid |
| s_ready_o | output | 1 | Sample beat ready |
| s_flags_i | input | NUM_CH | Per-channel abnormal flags |
| s_mag_i | input | NUM_CH*MAG_W | Per-channel magnitudes |
| scan_active_o | output | 1 | Window open |
| done_o | output | 1 | Ranked list valid pulse |
| rank_seg_o | output | TOP_K*4 | Ranked segment identifiers |
| rank_score_o | output | TOP_K*8 | Ranked scores |
| win_start_o | output | TS_W | Window open timestamp |
| win_end_o | output | TS_W | Window close timestamp |

## Verification
The bound properties assume that the alarm is low while reset is applied. This is why the rise of scan_active can be tied to a fresh low-to-high alarm edge. They also assume the configuration stays constant across a window and a sort, so the score order and rank distinctness hold at every done pulse. The stimulus keeps the alarm low through reset and changes configuration only while the engine is idle. It pulses the alarm inside windows and sort phases only to show that these pulses are ignored.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int SEG_W     = 4;
  localparam int SCORE_W   = 8;
  localparam int SCORE_MAX = 255;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_SORT} eng_state_e;

  // points granted to channels first going abnormal in the n-th crossing beat
  function automatic logic [2:0] lead_points(input logic [1:0] order);
    case (order)
      2'd0:    return 3'd4;
      2'd1:    return 3'd2;
      2'd2:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/fsr_ratio_cmp.sv
module fsr_ratio_cmp #(
  parameter int MAG_W   = 12,
  parameter int RATIO_W = 8
) (
  input  logic [MAG_W-1:0]   far_mag_i,
  input  logic [MAG_W-1:0]   near_mag_i,
  input  logic [RATIO_W-1:0] num_i,
  input  logic [RATIO_W-1:0] den_i,
  output logic               hit_o
);
  localparam int PROD_W = MAG_W + RATIO_W;

  logic [PROD_W-1:0] far_scaled, near_scaled;

  // far/near > num/den  <=>  far*den > near*num, no divider needed
  assign far_scaled  = PROD_W'(far_mag_i)  * PROD_W'(den_i);
  assign near_scaled = PROD_W'(near_mag_i) * PROD_W'(num_i);
  assign hit_o       = far_scaled > near_scaled;
endmodule

// File: rtl/fsr_score_bank.sv
module fsr_score_bank
  import fsr_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_SEG = 4,
  parameter int TS_W    = 16,
  parameter logic [NUM_CH*SEG_W-1:0] CH_SEG_MAP = 32'h3322_1100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       beat_i,
  input  logic [NUM_CH-1:0]          flags_i,
  input  logic                       ratio_hit_i,
  input  logic [SEG_W-1:0]           far_seg_i,
  input  logic [TS_W-1:0]            time_i,
  output logic [NUM_SEG*SCORE_W-1:0] score_o,
  output logic [NUM_SEG*TS_W-1:0]    first_ts_o,
  output logic [NUM_SEG-1:0]         hit_o
);
  localparam int ACC_W = SCORE_W + $clog2(NUM_CH * 5 + 2);

  logic [NUM_CH-1:0] crossed_q;
  logic [NUM_CH-1:0] new_x;
  logic [1:0]        order_q;
  logic [2:0]        pts;

  assign new_x = flags_i & ~crossed_q;
  assign pts   = lead_points(order_q);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      crossed_q <= '0;
      order_q   <= '0;
    end else if (beat_i) begin
      crossed_q <= crossed_q | flags_i;
      if (|new_x && order_q != 2'd3) order_q <= order_q + 2'd1;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [ACC_W-1:0]   add, sum;
    logic               any_new;
    logic [SCORE_W-1:0] score_q;
    logic [TS_W-1:0]    ts_q;
    logic               hit_q;

    always_comb begin
      add     = '0;
      any_new = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (CH_SEG_MAP[c*SEG_W +: SEG_W] == SEG_W'(s)) begin
          add = add + ACC_W'(flags_i[c]);
          if (new_x[c]) begin
            add     = add + ACC_W'(pts);
            any_new = 1'b1;
          end
        end
      end
      if (ratio_hit_i && far_seg_i == SEG_W'(s)) add = add + ACC_W'(1);
      sum = ACC_W'(score_q) + add;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
        score_q <= '0;
        ts_q    <= '0;
        hit_q   <= 1'b0;
      end else if (beat_i) begin
        score_q <= (sum > ACC_W'(SCORE_MAX)) ? SCORE_W'(SCORE_MAX) : sum[SCORE_W-1:0];
        if (any_new && !hit_q) begin
          hit_q <= 1'b1;
          ts_q  <= time_i;
        end
      end
    end

    assign score_o[s*SCORE_W +: SCORE_W] = score_q;
    assign first_ts_o[s*TS_W +: TS_W]    = ts_q;
    assign hit_o[s]                      = hit_q;
  end
endmodule

// File: rtl/fsr_topk_sorter.sv
module fsr_topk_sorter
  import fsr_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int TS_W    = 16,
  parameter int TOP_K   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_i,
  input  logic [NUM_SEG*SCORE_W-1:0] score_i,
  input  logic [NUM_SEG*TS_W-1:0]    ts_i,
  input  logic [NUM_SEG-1:0]         hit_i,
  output logic                       fin_o,
  output logic                       done_o,
  output logic [TOP_K*SEG_W-1:0]     rank_seg_o,
  output logic [TOP_K*SCORE_W-1:0]   rank_score_o
);
  localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;
  localparam int PASS_W = $clog2(TOP_K + 1);

  logic [IDX_W-1:0]   idx_q, best_q, nxt_best;
  logic               best_vld_q, take, last_idx, ahead;
  logic [PASS_W-1:0]  pass_q;
  logic [NUM_SEG-1:0] picked_q;
  logic [SEG_W-1:0]   res_seg_q [TOP_K];
  logic [SEG_W-1:0]   fin_seg   [TOP_K];
  logic [SCORE_W-1:0] fin_score [TOP_K];
  logic [SCORE_W-1:0] sa, sb;
  logic [TS_W-1:0]    ta, tb;
  logic               ha, hb;

  always_comb begin
    sa = score_i[int'(idx_q)*SCORE_W +: SCORE_W];
    sb = score_i[int'(best_q)*SCORE_W +: SCORE_W];
    ta = ts_i[int'(idx_q)*TS_W +: TS_W];
    tb = ts_i[int'(best_q)*TS_W +: TS_W];
    ha = hit_i[idx_q];
    hb = hit_i[best_q];
    // candidate index always exceeds best index, so equality keeps the lower index
    ahead    = (sa > sb) || ((sa == sb) && ((ha && !hb) || (ha && hb && (ta < tb))));
    take     = !picked_q[idx_q] && (!best_vld_q || ahead);
    nxt_best = take ? idx_q : best_q;
    last_idx = (idx_q == IDX_W'(NUM_SEG - 1));
    fin_o    = run_i && last_idx && (pass_q == PASS_W'(TOP_K - 1));
    for (int k = 0; k < TOP_K; k++) begin
      fin_seg[k]   = (k == TOP_K - 1) ? SEG_W'(nxt_best) : res_seg_q[k];
      fin_score[k] = score_i[int'(fin_seg[k])*SCORE_W +: SCORE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      idx_q      <= '0;
      best_q     <= '0;
      best_vld_q <= 1'b0;
      pass_q     <= '0;
      picked_q   <= '0;
    end else if (last_idx) begin
      res_seg_q[pass_q] <= SEG_W'(nxt_best);
      picked_q[nxt_best] <= 1'b1;
      best_vld_q <= 1'b0;
      best_q     <= '0;
      idx_q      <= '0;
      pass_q     <= pass_q + PASS_W'(1);
    end else begin
      idx_q      <= idx_q + IDX_W'(1);
      best_q     <= nxt_best;
      best_vld_q <= best_vld_q | take;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o       <= 1'b0;
      rank_seg_o   <= '0;
      rank_score_o <= '0;
    end else begin
      done_o <= fin_o;
      if (fin_o) begin
        for (int k = 0; k < TOP_K; k++) begin
          rank_seg_o[k*SEG_W +: SEG_W]       <= fin_seg[k];
          rank_score_o[k*SCORE_W +: SCORE_W] <= fin_score[k];
        end
      end
    end
  end
endmodule

// File: rtl/fsr_rank_engine.sv
module fsr_rank_engine
  import fsr_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_SEG = 4,
  parameter int MAG_W   = 12,
  parameter int RATIO_W = 8,
  parameter int TS_W    = 16,
  parameter int WIN_W   = 16,
  parameter int TOP_K   = 3,
  parameter logic [NUM_CH*SEG_W-1:0] CH_SEG_MAP = 32'h3322_1100,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alarm_i,
  input  logic [TS_W-1:0]          time_i,
  input  logic [WIN_W-1:0]         cfg_win_len,
  input  logic [CH_W-1:0]          cfg_far_ch,
  input  logic [CH_W-1:0]          cfg_near_ch,
  input  logic [RATIO_W-1:0]       cfg_ratio_num,
  input  logic [RATIO_W-1:0]       cfg_ratio_den,
  input  logic                     s_valid_i,
  output logic                     s_ready_o,
  input  logic [NUM_CH-1:0]        s_flags_i,
  input  logic [NUM_CH*MAG_W-1:0]  s_mag_i,
  output logic                     scan_active_o,
  output logic                     done_o,
  output logic [TOP_K*SEG_W-1:0]   rank_seg_o,
  output logic [TOP_K*SCORE_W-1:0] rank_score_o,
  output logic [TS_W-1:0]          win_start_o,
  output logic [TS_W-1:0]          win_end_o
);
  eng_state_e state_q;
  logic              alarm_q, alarm_rise;
  logic [WIN_W-1:0]  beat_cnt_q;
  logic              beat_in_win, last_beat, clear_scores, ratio_hit, sort_fin;
  logic [MAG_W-1:0]  far_mag, near_mag;
  logic [SEG_W-1:0]  far_seg;
  logic [NUM_SEG*SCORE_W-1:0] seg_score;
  logic [NUM_SEG*TS_W-1:0]    seg_ts;
  logic [NUM_SEG-1:0]         seg_hit;

  assign alarm_rise    = alarm_i & ~alarm_q;
  assign s_ready_o     = (state_q != ST_SORT);
  assign scan_active_o = (state_q == ST_SCAN);
  assign beat_in_win   = s_valid_i && s_ready_o && (state_q == ST_SCAN);
  assign last_beat     = beat_in_win &&
                         (({1'b0, beat_cnt_q} + (WIN_W+1)'(1)) >= {1'b0, cfg_win_len});
  assign clear_scores  = (state_q == ST_IDLE) && alarm_rise;

  always_comb begin
    far_mag  = s_mag_i[int'(cfg_far_ch)*MAG_W +: MAG_W];
    near_mag = s_mag_i[int'(cfg_near_ch)*MAG_W +: MAG_W];
    far_seg  = CH_SEG_MAP[int'(cfg_far_ch)*SEG_W +: SEG_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      alarm_q     <= 1'b1;
      beat_cnt_q  <= '0;
      win_start_o <= '0;
      win_end_o   <= '0;
    end else begin
      alarm_q <= alarm_i;
      case (state_q)
        ST_IDLE: if (alarm_rise) begin
          state_q     <= ST_SCAN;
          beat_cnt_q  <= '0;
          win_start_o <= time_i;
        end
        ST_SCAN: if (beat_in_win) begin
          if (last_beat) begin
            state_q   <= ST_SORT;
            win_end_o <= time_i;
          end else begin
            beat_cnt_q <= beat_cnt_q + WIN_W'(1);
          end
        end
        ST_SORT: if (sort_fin) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  fsr_ratio_cmp #(.MAG_W(MAG_W), .RATIO_W(RATIO_W)) u_ratio (
    .far_mag_i  (far_mag),
    .near_mag_i (near_mag),
    .num_i      (cfg_ratio_num),
    .den_i      (cfg_ratio_den),
    .hit_o      (ratio_hit)
  );

  fsr_score_bank #(
    .NUM_CH(NUM_CH), .NUM_SEG(NUM_SEG), .TS_W(TS_W), .CH_SEG_MAP(CH_SEG_MAP)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_scores),
    .beat_i      (beat_in_win),
    .flags_i     (s_flags_i),
    .ratio_hit_i (ratio_hit),
    .far_seg_i   (far_seg),
    .time_i      (time_i),
    .score_o     (seg_score),
    .first_ts_o  (seg_ts),
    .hit_o       (seg_hit)
  );

  fsr_topk_sorter #(.NUM_SEG(NUM_SEG), .TS_W(TS_W), .TOP_K(TOP_K)) u_sort (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (state_q == ST_SORT),
    .score_i      (seg_score),
    .ts_i         (seg_ts),
    .hit_i        (seg_hit),
    .fin_o        (sort_fin),
    .done_o       (done_o),
    .rank_seg_o   (rank_seg_o),
    .rank_score_o (rank_score_o)
  );
endmodule

// File: rtl/fsr_rank_engine_chk.sv
module fsr_rank_engine_chk
  import fsr_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int TS_W    = 16,
  parameter int TOP_K   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     alarm_i,
  input logic                     s_ready_o,
  input logic                     scan_active_o,
  input logic                     done_o,
  input logic [TOP_K*SEG_W-1:0]   rank_seg_o,
  input logic [TOP_K*SCORE_W-1:0] rank_score_o,
  input logic [TS_W-1:0]          win_start_o
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  rank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(rank_seg_o) && $stable(rank_score_o)));

  // R10
  ready_sort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready_o |-> !scan_active_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (s_ready_o && !scan_active_o));

  // R11
  scan_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_active_o) |-> ($past(alarm_i) && !$past(alarm_i, 2)));

  // R2
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_active_o && $past(scan_active_o)) |-> $stable(win_start_o));

  for (genvar k = 0; k < TOP_K; k++) begin : g_rank
    // R8
    rank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (int'(rank_seg_o[k*SEG_W +: SEG_W]) < NUM_SEG));
    if (k > 0) begin : g_pair
      // R8
      rank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rank_score_o[(k-1)*SCORE_W +: SCORE_W] >= rank_score_o[k*SCORE_W +: SCORE_W]));
      for (genvar j = 0; j < k; j++) begin : g_dis
        // R8
        rank_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
          done_o |-> (rank_seg_o[j*SEG_W +: SEG_W] != rank_seg_o[k*SEG_W +: SEG_W]));
      end
    end
  end
endmodule

bind fsr_rank_engine fsr_rank_engine_chk #(
  .NUM_SEG(NUM_SEG), .TS_W(TS_W), .TOP_K(TOP_K)
) u_chk (.*);

// File: tb/fsr_rank_engine_tb.sv
module fsr_rank_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH  = 8;
  localparam int NUM_SEG = 4;
  localparam int MAG_W   = 12;
  localparam int TOP_K   = 3;
  localparam int TS_W    = 16;

  logic clk = 0, rst_n = 0, alarm = 0, s_valid = 0;
  logic [TS_W-1:0] time_r = '0;
  logic [15:0] cfg_len = 16'd1;
  logic [2:0]  cfg_far = 3'd6, cfg_near = 3'd0;
  logic [7:0]  cfg_num = 8'd255, cfg_den = 8'd1;
  logic [NUM_CH-1:0] s_flags = '0;
  logic [NUM_CH*MAG_W-1:0] s_mag = '0;
  logic s_ready, scan_active, done;
  logic [TOP_K*4-1:0] rank_seg;
  logic [TOP_K*8-1:0] rank_score;
  logic [TS_W-1:0] win_start, win_end;

  int vectors = 0, errors = 0;

  // bench model of the scoring rules
  int m_score[NUM_SEG];
  bit m_hit[NUM_SEG];
  int m_ts[NUM_SEG];
  bit m_crossed[NUM_CH];
  int m_order, m_beats, m_len;
  bit m_open;
  int exp_start, exp_end;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) time_r <= time_r + 1'b1;

  fsr_rank_engine u_dut (
    .clk(clk), .rst_n(rst_n), .alarm_i(alarm), .time_i(time_r),
    .cfg_win_len(cfg_len), .cfg_far_ch(cfg_far), .cfg_near_ch(cfg_near),
    .cfg_ratio_num(cfg_num), .cfg_ratio_den(cfg_den),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_flags_i(s_flags), .s_mag_i(s_mag),
    .scan_active_o(scan_active), .done_o(done),
    .rank_seg_o(rank_seg), .rank_score_o(rank_score),
    .win_start_o(win_start), .win_end_o(win_end)
  );

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int seg_of(input int c);
    return c / 2;  // default map stated in R5
  endfunction

  function automatic bit m_ahead(input int a, input int b);
    if (m_score[a] != m_score[b]) return m_score[a] > m_score[b];
    if (m_hit[a] != m_hit[b]) return m_hit[a];
    if (m_hit[a] && m_ts[a] != m_ts[b]) return m_ts[a] < m_ts[b];
    return a < b;
  endfunction

  task automatic model_beat(input logic [NUM_CH-1:0] fl, input int far_m, input int near_m, input int t);
    int pts;
    bit any;
    int add[NUM_SEG];
    pts = (m_order == 0) ? 4 : (m_order == 1) ? 2 : (m_order == 2) ? 1 : 0;
    any = 0;
    for (int s = 0; s < NUM_SEG; s++) add[s] = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (fl[c]) begin
        add[seg_of(c)] += 1;
        if (!m_crossed[c]) begin
          add[seg_of(c)] += pts;
          any = 1;
          m_crossed[c] = 1;
          if (!m_hit[seg_of(c)]) begin
            m_hit[seg_of(c)] = 1;
            m_ts[seg_of(c)] = t;
          end
        end
      end
    end
    if (far_m * int'(cfg_den) > near_m * int'(cfg_num)) add[seg_of(int'(cfg_far))] += 1;
    for (int s = 0; s < NUM_SEG; s++) begin
      m_score[s] += add[s];
      if (m_score[s] > 255) m_score[s] = 255;
    end
    if (any && m_order < 3) m_order++;
  endtask

  task automatic open_window(input int len, input string tag);
    cfg_len = 16'(len);
    @(negedge clk) alarm = 0;
    @(negedge clk) alarm = 1;
    #1 exp_start = int'(time_r);
    @(posedge clk);
    @(negedge clk);
    chk(scan_active == 1'b1, {"R2 open ", tag}, int'(scan_active), 1);
    chk(int'(win_start) == exp_start, {"R2 start ", tag}, int'(win_start), exp_start);
    for (int s = 0; s < NUM_SEG; s++) begin
      m_score[s] = 0; m_hit[s] = 0; m_ts[s] = 0;
    end
    for (int c = 0; c < NUM_CH; c++) m_crossed[c] = 0;
    m_order = 0; m_beats = 0; m_len = len; m_open = 1;
  endtask

  task automatic beat(input logic [NUM_CH-1:0] fl, input int far_m, input int near_m);
    int t;
    @(negedge clk);
    s_valid = 1;
    s_flags = fl;
    s_mag = '0;
    s_mag[6*MAG_W +: MAG_W] = MAG_W'(far_m);
    s_mag[0 +: MAG_W]       = MAG_W'(near_m);
    #1 t = int'(time_r);
    if (m_open) begin
      model_beat(fl, far_m, near_m, t);
      m_beats++;
      if (m_beats == m_len) begin
        m_open = 0;
        exp_end = t;
      end
    end
    @(posedge clk);
  endtask

  task automatic finish_window(input string tag);
    int n;
    int best;
    bit picked[NUM_SEG];
    @(negedge clk);
    s_valid = 0;
    s_flags = '0;
    n = 0;
    chk(s_ready == 1'b0, {"R10 ready low in sort ", tag}, int'(s_ready), 0);
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3*NUM_SEG, {"R9 sort latency ", tag}, n, 3*NUM_SEG);
    chk(int'(win_end) == exp_end, {"R3 end ", tag}, int'(win_end), exp_end);
    for (int s = 0; s < NUM_SEG; s++) picked[s] = 0;
    for (int k = 0; k < TOP_K; k++) begin
      best = -1;
      for (int s = 0; s < NUM_SEG; s++)
        if (!picked[s] && (best < 0 || m_ahead(s, best))) best = s;
      picked[best] = 1;
      chk(int'(rank_seg[k*4 +: 4]) == best, {"R8 seg ", tag}, int'(rank_seg[k*4 +: 4]), best);
      chk(int'(rank_score[k*8 +: 8]) == m_score[best], {"R8 score ", tag},
          int'(rank_score[k*8 +: 8]), m_score[best]);
    end
    @(negedge clk);
    chk(done == 1'b0, {"R9 pulse ", tag}, int'(done), 0);
  endtask

  task automatic t_reset();
    chk(rank_seg == '0 && rank_score == '0, "R1 ranks", int'(rank_score), 0);
    chk(win_start == '0 && win_end == '0, "R1 stamps", int'(win_start), 0);
    chk(done == 0 && scan_active == 0, "R1 ctrl", int'(done), 0);
    chk(s_ready == 1, "R1 ready", int'(s_ready), 1);
  endtask

  task automatic t_idle_ignore();
    m_open = 0;
    for (int i = 0; i < 5; i++) beat(8'hFF, 200, 0);
    @(negedge clk) s_valid = 0;
    chk(scan_active == 0, "R10 idle no window", int'(scan_active), 0);
    chk(s_ready == 1, "R10 ready idle", int'(s_ready), 1);
    open_window(2, "idle");
    beat(8'h00, 0, 0);
    beat(8'h00, 0, 0);
    finish_window("idle");
    chk(rank_seg == 12'h210 && rank_score == '0, "R10 idle beats no score", int'(rank_score), 0);
  endtask

  task automatic t_order();
    open_window(4, "order");
    beat(8'b0001_0000, 0, 0);
    beat(8'b0001_0001, 0, 0);
    beat(8'b0101_0001, 0, 0);
    beat(8'b0000_0100, 0, 0);
    finish_window("order");
    chk(rank_score[7:0] == 8'd7 && rank_seg[3:0] == 4'd2, "R4 lead points", int'(rank_score[7:0]), 7);
    chk(rank_score[15:8] == 8'd4, "R5 persistence", int'(rank_score[15:8]), 4);
  endtask

  task automatic t_tie_ts();
    open_window(4, "tie");
    beat(8'b0100_0000, 0, 0);
    beat(8'b0100_0100, 0, 0);
    beat(8'b0000_0001, 0, 0);
    beat(8'b0000_0001, 0, 0);
    finish_window("tie");
    chk(rank_seg == 12'h013, "R8 earlier crossing wins tie", int'(rank_seg), 'h013);
  endtask

  task automatic t_ratio();
    cfg_num = 8'd2; cfg_den = 8'd1;
    open_window(5, "ratio");
    beat(8'b0001_0100, 100, 40);
    beat(8'b0000_0000, 100, 40);
    beat(8'b0000_0000, 100, 40);
    beat(8'b0000_0000, 80, 40);
    beat(8'b0000_0000, 80, 40);
    finish_window("ratio");
    chk(rank_seg == 12'h321, "R4 shared crossing and index tie", int'(rank_seg), 'h321);
    chk(rank_score[23:16] == 8'd3, "R6 ratio credit", int'(rank_score[23:16]), 3);
    cfg_num = 8'd255; cfg_den = 8'd1;
  endtask

  task automatic t_saturate();
    open_window(140, "sat");
    for (int i = 0; i < 140; i++) beat(8'b0011_0000, 0, 0);
    finish_window("sat");
    chk(rank_score[7:0] == 8'd255 && rank_seg[3:0] == 4'd2, "R7 saturation", int'(rank_score[7:0]), 255);
  endtask

  task automatic t_alarm_scan();
    open_window(6, "scanalarm");
    beat(8'b0000_0010, 0, 0);
    alarm = 0;
    beat(8'b0000_0010, 0, 0);
    alarm = 1;
    beat(8'b0000_0010, 0, 0);
    beat(8'b0000_0000, 0, 0);
    chk(int'(win_start) == exp_start, "R11 start kept", int'(win_start), exp_start);
    chk(scan_active == 1, "R11 window continues", int'(scan_active), 1);
    beat(8'b0000_0000, 0, 0);
    beat(8'b0000_0000, 0, 0);
    finish_window("scanalarm");
  endtask

  task automatic t_alarm_sort();
    open_window(1, "sortalarm");
    beat(8'b1000_0000, 0, 0);
    @(negedge clk) s_valid = 0;
    alarm = 0;
    @(negedge clk) alarm = 1;
    while (!done) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(scan_active == 0, "R11 alarm in sort ignored", int'(scan_active), 0);
    end
    alarm = 0;
  endtask

  initial begin
    m_open = 0;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1;
    repeat (2) @(negedge clk);
    t_idle_ignore();
    t_order();
    t_tie_ts();
    t_ratio();
    t_saturate();
    t_alarm_scan();
    t_alarm_sort();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule